// File: doc/BRIEF.md
# Priority Region Memory Protection Checker

This block decides, in the same cycle, whether a memory access may go ahead. It holds a small bank of region descriptors that software programs through a simple register bus. Each descriptor has two words. The base word carries the region start address and a valid flag. The permission word carries access attributes and a size exponent split across two fields. Every region is naturally aligned and has a power-of-two size of at least 2 KiB. Regions may overlap. When more than one valid region covers an address, the region with the lowest index decides.

For each access the block receives an address, a user/kernel flag and a read/write flag. It names the winning region and returns allow or deny from that region's attributes. If no region covers the address, it uses a default attribute set held in the control register. Clearing the global enable lets every access through. One cycle after a denied access it raises a registered deny pulse, which other logic can use to start an exception.

Top module: `prio_mpu`

## Requirements
- R1: After reset, all regions are invalid, the global enable is clear, the default attributes are zero, `acc_allow` is 1 and `deny_q` is 0.
- R2: Register map. Region n has its base word at offset 2n and its permission word at offset 2n+1. The control word is at 0x20 and the build word at 0x21. Reads return the stored value: all address bits of a base word, and bits [11:0] of a permission word with the upper bits zero. The control word reads back as enable at bit 30 and default attributes at [11:0]. Unmapped offsets read zero.
- R3: The build word reads back with the number of implemented regions (parameter `NREG`, at most 16) in bits [15:8] and zeros in all other bits.
- R4: A write to a region slot at or above `NREG` changes no state, and that slot reads zero. `acc_idx` never names such a slot.
- R5: While control bit 30 is 0, `acc_allow` is 1 for every access. Region matching is still reported on `acc_hit`/`acc_idx`.
- R6: A region matches when bit 0 of its base word is 1 and the access address lies in [B, B + 2^E). Here E = F + 1, F = {perm[11:9], perm[1:0]}, and B is the base address with its low E bits cleared.
- R7: A decoded E below `MIN_EXP` (default 11) is raised to `MIN_EXP`, so the smallest region is 2 KiB.
- R8: When several regions match, the lowest index wins. `acc_hit` is 1 and `acc_idx` gives that index. With no match, `acc_hit` is 0.
- R9: The winning attributes are checked by mode and direction. User read needs bit 2, user write needs bit 3, kernel read needs bit 4, and kernel write needs bit 5.
- R10: With the enable set and no region matching, the control word's default attributes [11:0] decide, using the same bit meanings as R9.
- R11: `deny_q` is 1 in the cycle after a cycle in which `acc_valid` was 1 and `acc_allow` was 0. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word offset for both reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data at `cfg_addr` |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_user | input | 1 | 1 = user mode, 0 = kernel mode |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_allow | output | 1 | Combinational permission result |
| acc_hit | output | 1 | Some valid region covers the address |
| acc_idx | output | 4 | Index of the deciding region |
| deny_q | output | 1 | Registered deny pulse, one cycle after a denied access |

## Verification
Two things can happen in the same cycle: a register write that reshapes a region or flips the enable, and an access whose verdict depends on that state. The bench issues register writes while accesses keep flowing, both in directed steps and in a randomized phase. This checks that the verdict seen in the write cycle still uses the old descriptors, and that `deny_q` in the next cycle reflects that old verdict. A behavioural model updates its own copy of the descriptors at each clock edge, after it has computed the registered deny expectation. Every cycle it compares the allow, hit, index, deny and read-data outputs against that model.

// File: rtl/prio_mpu_pkg.sv
package prio_mpu_pkg;
   localparam int MAX_REGIONS = 16;
   localparam int ATTR_W      = 12;
   localparam int DATA_W      = 32;
   localparam int IDX_W       = $clog2(MAX_REGIONS);
   localparam int CFG_AW      = $clog2(2 * MAX_REGIONS) + 1;
   localparam int EXP_W       = 6;
   localparam int EN_BIT      = 30;
   localparam int UR_BIT      = 2;
   localparam int UW_BIT      = 3;
   localparam int KR_BIT      = 4;
   localparam int KW_BIT      = 5;
   localparam logic [CFG_AW-1:0] CTL_OFS = CFG_AW'(2 * MAX_REGIONS);
   localparam logic [CFG_AW-1:0] BLD_OFS = CFG_AW'(2 * MAX_REGIONS + 1);

   typedef logic [ATTR_W-1:0] attr_t;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
   import prio_mpu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int MIN_EXP = 11
) (
   input  logic [AW-1:0] base_w,
   input  attr_t         perm_w,
   input  logic [AW-1:0] addr,
   output logic          hit
);
   logic [4:0]       size_f;
   logic [EXP_W-1:0] exp_raw;
   logic [EXP_W-1:0] exp_eff;
   logic [AW-1:0]    keep;

   assign size_f  = {perm_w[11:9], perm_w[1:0]};
   assign exp_raw = EXP_W'(size_f) + EXP_W'(1);
   assign exp_eff = (exp_raw < EXP_W'(MIN_EXP)) ? EXP_W'(MIN_EXP) : exp_raw;

   for (genvar b = 0; b < AW; b++) begin : g_keep
      assign keep[b] = (EXP_W'(b) >= exp_eff);
   end

   assign hit = base_w[0] && (((addr ^ base_w) & keep) == '0);
endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick
   import prio_mpu_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     grant
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   assign grant = hits & ~(hits - N'(1));
endmodule

// File: rtl/mpu_perm_eval.sv
module mpu_perm_eval
   import prio_mpu_pkg::*;
(
   input  attr_t attr,
   input  logic  user,
   input  logic  write,
   output logic  ok
);
   always_comb begin
      unique case ({user, write})
         2'b10:   ok = attr[UR_BIT];
         2'b11:   ok = attr[UW_BIT];
         2'b00:   ok = attr[KR_BIT];
         default: ok = attr[KW_BIT];
      endcase
   end
endmodule

// File: rtl/prio_mpu.sv
module prio_mpu
   import prio_mpu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NREG    = 8,
   parameter int MIN_EXP = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              acc_valid,
   input  logic [AW-1:0]     acc_addr,
   input  logic              acc_user,
   input  logic              acc_write,
   output logic              acc_allow,
   output logic              acc_hit,
   output logic [IDX_W-1:0]  acc_idx,
   output logic              deny_q
);
   localparam int SLOT_W = CFG_AW - 1;

   if (NREG < 1 || NREG > MAX_REGIONS) begin : g_bad_nreg
      $error("prio_mpu: NREG must lie in 1..16");
   end
   if (AW > DATA_W || AW <= MIN_EXP) begin : g_bad_aw
      $error("prio_mpu: AW must exceed MIN_EXP and fit the data word");
   end
   if (MIN_EXP < 1) begin : g_bad_exp
      $error("prio_mpu: MIN_EXP must be positive");
   end

   logic [AW-1:0] base_q [NREG];
   attr_t         perm_q [NREG];
   logic          en_q;
   attr_t         dflt_q;

   logic              in_rgn;
   logic [SLOT_W-1:0] slot;
   assign in_rgn = (cfg_addr[CFG_AW-1] == 1'b0);
   assign slot   = cfg_addr[CFG_AW-1:1];

   for (genvar r = 0; r < NREG; r++) begin : g_desc
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[r] <= '0;
            perm_q[r] <= '0;
         end else if (cfg_wr && in_rgn && slot == SLOT_W'(r)) begin
            if (cfg_addr[0]) perm_q[r] <= cfg_wdata[ATTR_W-1:0];
            else             base_q[r] <= cfg_wdata[AW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         dflt_q <= '0;
      end else if (cfg_wr && cfg_addr == CTL_OFS) begin
         en_q   <= cfg_wdata[EN_BIT];
         dflt_q <= cfg_wdata[ATTR_W-1:0];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (in_rgn) begin
         for (int r = 0; r < NREG; r++) begin
            if (slot == SLOT_W'(r)) begin
               cfg_rdata = cfg_addr[0] ? DATA_W'(perm_q[r]) : DATA_W'(base_q[r]);
            end
         end
      end else if (cfg_addr == CTL_OFS) begin
         cfg_rdata[EN_BIT]       = en_q;
         cfg_rdata[ATTR_W-1:0]   = dflt_q;
      end else if (cfg_addr == BLD_OFS) begin
         cfg_rdata[15:8] = 8'(NREG);
      end
   end

   logic [NREG-1:0] hits;
   logic [NREG-1:0] grant;

   for (genvar r = 0; r < NREG; r++) begin : g_match
      mpu_region_match #(.AW(AW), .MIN_EXP(MIN_EXP)) u_match (
         .base_w (base_q[r]),
         .perm_w (perm_q[r]),
         .addr   (acc_addr),
         .hit    (hits[r])
      );
   end

   mpu_prio_pick #(.N(NREG)) u_pick (
      .hits  (hits),
      .any   (acc_hit),
      .idx   (acc_idx),
      .grant (grant)
   );

   attr_t win_attr;
   always_comb begin
      win_attr = dflt_q;
      for (int r = 0; r < NREG; r++) begin
         if (grant[r]) win_attr = perm_q[r];
      end
   end

   logic perm_ok;
   mpu_perm_eval u_eval (
      .attr  (win_attr),
      .user  (acc_user),
      .write (acc_write),
      .ok    (perm_ok)
   );

   assign acc_allow = !en_q || perm_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) deny_q <= 1'b0;
      else        deny_q <= acc_valid && !acc_allow;
   end
endmodule

// File: rtl/prio_mpu_chk.sv
module prio_mpu_chk
   import prio_mpu_pkg::*;
#(
   parameter int NREG = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              acc_valid,
   input logic              acc_allow,
   input logic              acc_hit,
   input logic [IDX_W-1:0]  acc_idx,
   input logic              deny_q,
   input logic              en_q,
   input logic [NREG-1:0]   hits,
   input logic [NREG-1:0]   grant
);
   AST_DENY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_allow) |=> deny_q); // R11
   AST_DENY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_allow) |=> !deny_q); // R11
   AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> acc_allow); // R5
   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8
   AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit == (hits != '0)); // R8
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit |-> (int'(acc_idx) < NREG)); // R4
   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == CTL_OFS) |=> (en_q == $past(cfg_wdata[EN_BIT]))); // R2
endmodule

bind prio_mpu prio_mpu_chk #(.NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .acc_valid (acc_valid),
   .acc_allow (acc_allow),
   .acc_hit   (acc_hit),
   .acc_idx   (acc_idx),
   .deny_q    (deny_q),
   .en_q      (en_q),
   .hits      (hits),
   .grant     (grant)
);

// File: tb/prio_mpu_test.sv
`timescale 1ns/1ps
module prio_mpu_test;
   localparam int NREG = 8;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_wr = 0;
   logic [5:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 0;
   logic [31:0] acc_addr = 0;
   logic        acc_user = 0;
   logic        acc_write = 0;
   logic        acc_allow, acc_hit, deny_q;
   logic [3:0]  acc_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   prio_mpu #(.AW(32), .NREG(NREG), .MIN_EXP(11)) uut (.*);

   // behavioural reference
   logic [31:0] m_base [16];
   logic [11:0] m_perm [16];
   bit          m_en;
   logic [11:0] m_dflt;
   bit          exp_deny;

   function automatic void model_eval(input logic [31:0] a, input bit u, input bit w,
                                      output bit allow, output bit hit, output int idx);
      logic [11:0] attr;
      int bitpos;
      hit = 0; idx = 0; attr = m_dflt;
      for (int i = 0; i < NREG; i++) begin
         int e;
         bit m;
         e = int'({m_perm[i][11:9], m_perm[i][1:0]}) + 1;
         if (e < 11) e = 11;
         m = (e >= 32) ? 1'b1 : ((a >> e) == (m_base[i] >> e));
         if (!hit && m_base[i][0] && m) begin
            hit = 1; idx = i; attr = m_perm[i];
         end
      end
      bitpos = u ? (w ? 3 : 2) : (w ? 5 : 4);
      allow = !m_en || attr[bitpos];
   endfunction

   function automatic logic [31:0] model_read(input logic [5:0] a);
      if (a < 32) begin
         if (int'(a >> 1) >= NREG) return 32'h0;
         return a[0] ? {20'h0, m_perm[a >> 1]} : m_base[a >> 1];
      end
      if (a == 6'h20) return (32'(m_en) << 30) | {20'h0, m_dflt};
      if (a == 6'h21) return 32'(NREG) << 8;
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      bit al, h;
      int ix;
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_perm[i] = 0; end
         m_en = 0; m_dflt = 0; exp_deny = 0;
      end else begin
         model_eval(acc_addr, acc_user, acc_write, al, h, ix);
         exp_deny = acc_valid && !al;
         if (cfg_wr) begin
            if (cfg_addr < 32 && int'(cfg_addr >> 1) < NREG) begin
               if (cfg_addr[0]) m_perm[cfg_addr >> 1] = cfg_wdata[11:0];
               else             m_base[cfg_addr >> 1] = cfg_wdata;
            end else if (cfg_addr == 6'h20) begin
               m_en = cfg_wdata[30]; m_dflt = cfg_wdata[11:0];
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison in mid-cycle
   always @(negedge clk) begin
      bit al, h;
      int ix;
      if (rst_n && !done) begin
         model_eval(acc_addr, acc_user, acc_write, al, h, ix);
         chk("R9 allow vs model", 32'(acc_allow), 32'(al));
         chk("R6 hit vs model", 32'(acc_hit), 32'(h));
         if (h) chk("R8 index vs model", 32'(acc_idx), 32'(ix));
         chk("R11 deny vs model", 32'(deny_q), 32'(exp_deny));
         chk("R2 read data vs model", cfg_rdata, model_read(cfg_addr));
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_wr = 0;
   endtask

   task automatic acc(input logic [31:0] a, input bit u, input bit w);
      acc_valid = 1; acc_addr = a; acc_user = u; acc_write = w; #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      #1;
      // R1 reset state
      chk("R1 allow after reset", 32'(acc_allow), 1);
      chk("R1 deny after reset", 32'(deny_q), 0);
      cfg_addr = 6'h20; #1;
      chk("R1 control after reset", cfg_rdata, 32'h0);
      cfg_addr = 6'h00; #1;
      chk("R1 region0 base after reset", cfg_rdata, 32'h0);
      // R3 build word
      cfg_addr = 6'h21; #1;
      chk("R3 build word", cfg_rdata, 32'h0000_0800);

      // program regions: 0 = 4 KiB, 1 = 64 KiB overlapping, 2 = undersized
      wr(6'h00, 32'h1000_0001);
      wr(6'h01, 32'h0000_0437);
      wr(6'h02, 32'h1000_0001);
      wr(6'h03, 32'h0000_063F);
      wr(6'h04, 32'h3000_0001);
      wr(6'h05, 32'h0000_003C);
      cfg_addr = 6'h01; #1;
      chk("R2 perm readback", cfg_rdata, 32'h0000_0437);

      // R5 disabled: user write in read-only region still allowed
      acc(32'h1000_0100, 1, 1);
      chk("R5 allowed while disabled", 32'(acc_allow), 1);
      chk("R5 match still reported", 32'(acc_hit), 1);

      // enable with kernel-read-only default; write and access share a cycle
      cfg_wr = 1; cfg_addr = 6'h20; cfg_wdata = 32'h4000_0010;
      acc(32'h1000_0100, 1, 1);
      chk("R5 old enable still governs write cycle", 32'(acc_allow), 1);
      tick(); cfg_wr = 0;
      chk("R11 no deny from pre-enable access", 32'(deny_q), 0);
      chk("R8 overlap lowest index", 32'(acc_idx), 0);
      chk("R9 user write denied by region0", 32'(acc_allow), 0);
      tick();
      chk("R11 deny pulse next cycle", 32'(deny_q), 1);
      acc_valid = 0; tick();
      chk("R11 deny clears", 32'(deny_q), 0);

      acc(32'h1000_0100, 1, 0);
      chk("R9 user read allowed", 32'(acc_allow), 1);
      acc(32'h1000_0FFF, 0, 1);
      chk("R6 last byte of region0", 32'(acc_idx), 0);
      acc(32'h1000_1000, 1, 1);
      chk("R6 first byte past region0", 32'(acc_idx), 1);
      chk("R9 region1 user write allowed", 32'(acc_allow), 1);
      acc(32'h1001_0000, 1, 0);
      chk("R6 past region1 no hit", 32'(acc_hit), 0);

      // R10 default attributes
      acc(32'h2000_0000, 0, 0);
      chk("R10 default kernel read", 32'(acc_allow), 1);
      acc(32'h2000_0000, 0, 1);
      chk("R10 default kernel write", 32'(acc_allow), 0);

      // R7 clamp to 2 KiB
      acc(32'h3000_07FF, 1, 1);
      chk("R7 clamped region covers 0x7FF", 32'(acc_hit), 1);
      chk("R7 clamped region index", 32'(acc_idx), 2);
      acc(32'h3000_0800, 1, 1);
      chk("R7 clamped region ends at 2 KiB", 32'(acc_hit), 0);

      // R4 slot beyond NREG
      wr(6'h10, 32'h2000_0001);
      wr(6'h11, 32'h0000_003C);
      cfg_addr = 6'h10; #1;
      chk("R4 unimplemented slot reads zero", cfg_rdata, 32'h0);
      acc(32'h2000_0000, 0, 1);
      chk("R4 unimplemented slot has no effect", 32'(acc_hit), 0);

      // invalidate region 0: region 1 takes over
      wr(6'h00, 32'h1000_0000);
      acc(32'h1000_0100, 1, 1);
      chk("R6 invalid region skipped", 32'(acc_idx), 1);

      // randomized phase with concurrent writes
      for (int n = 0; n < 400; n++) begin
         acc(32'h1000_0000 + ($urandom & 32'h0003_FFFF), $urandom & 1, $urandom & 1);
         acc_valid = $urandom & 1;
         if (($urandom & 7) == 0) begin
            int r;
            r = $urandom % 4;
            cfg_wr = 1;
            cfg_addr = 6'(2 * r + ($urandom & 1));
            cfg_wdata = cfg_addr[0] ? ($urandom & 32'hFFF)
                                    : (32'h1000_0000 | ($urandom & 32'h0003_F801));
         end else if (($urandom & 31) == 0) begin
            cfg_wr = 1; cfg_addr = 6'h20;
            cfg_wdata = ($urandom & 32'h4000_0FFF);
         end else begin
            cfg_wr = 0; cfg_addr = 6'($urandom % 40);
         end
         tick();
         cfg_wr = 0;
      end
      acc_valid = 0;
      tick(); tick();
      finish_run();
   end
endmodule